// File: doc/BRIEF.md
# Panel Register Write Sequencer

This block configures a small TFT panel by writing its 16-bit internal registers over a write-only serial link. It owns the serial shift engine. Every register write goes out as two separate chip-select-framed transfers of three bytes each. The first is an index transfer that names the register. The second is a data transfer that carries the 16-bit value.

Three hardwired sequences sit above the register write, and a one-cycle command pulse starts each one:

- **Power-up** switches the panel on and then programs the output-control mode word.
- **Shutdown** puts the panel into its off state.
- **Resume** first restores the mode word that was last stored and only then switches the panel on.

The system side watches a busy level and a one-cycle done pulse. An error flag reports a link fault seen during any transfer of the sequence that has just finished. A link fault is signalled by the `link_err` input.

Top module: `panel_cfg_seq`

## Requirements
- R1: Each register write sends exactly two frames of 24 bits, most significant bit first. The index frame is the bytes 0x74, 0x00, register number. The data frame is the bytes 0x76, value bits 15..8, value bits 7..0.
- R2: The link uses SPI mode 3. `spi_sclk` is high whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sclk` is low, on a falling edge, or when chip select is asserted. Each low phase of `spi_sclk` lasts HALF_DIV system clocks.
- R3: Between two frames, `spi_cs_n` stays high for at least one serial clock period, which is 2*HALF_DIV system clocks.
- R4: The power-up sequence writes register 0x11 with 0x0000 and then register 0x01 with the mode word built from `mode_cfg`.
- R5: The shutdown sequence writes register 0x11 with 0x0001 and nothing else.
- R6: The resume sequence writes register 0x01 with the stored mode word and then register 0x11 with 0x0000.
- R7: The mode word is 0x2AEF with bits 8, 9, 12 and 13 cleared, giving 0x08EF. `mode_cfg[0]`, `[1]`, `[2]` and `[3]` are then placed in bits 8, 9, 12 and 13 respectively. `mode_cfg` is sampled when the command is accepted.
- R8: If `link_err` is high in any cycle while a frame is in progress, `error` is 1 when `done` pulses. The sequence still sends all of its frames. `link_err` outside a frame has no effect. `error` holds until the next command is accepted, which clears it.
- R9: `mode_word` takes the new mode word only at the end of a power-up sequence that had no link fault. Otherwise it keeps its previous value.
- R10: A command that arrives while `busy` is high is ignored. When several command inputs are high in the same idle cycle, power-up takes priority over resume, and resume takes priority over shutdown.
- R11: `busy` rises in the cycle after an accepted command. `done` is high for exactly one cycle, and it is high in the same cycle that `busy` falls.
- R12: After reset, `spi_cs_n`=1, `spi_sclk`=1, `busy`=0, `done`=0, `error`=0 and `mode_word`=0x08EF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_power_up | input | 1 | Start pulse for the power-up sequence |
| cmd_shutdown | input | 1 | Start pulse for the shutdown write |
| cmd_resume | input | 1 | Start pulse for the resume sequence |
| mode_cfg | input | 4 | Orientation and colour-order bits merged into the mode word |
| link_err | input | 1 | Fault indication from the link, observed while a frame is in progress |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |
| error | output | 1 | The last sequence saw a link fault |
| mode_word | output | 16 | Stored output-control mode word |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |

## Verification
`busy` becomes due one cycle after the edge that samples a command, so the bench reads it at the first falling clock edge after that edge. `done`, `error` and the updated `mode_word` are all due in the same cycle, and the bench waits for the first falling edge at which `done` is seen and checks all of them there. It then confirms one cycle later that `done` has dropped. Serial frames are captured bit by bit on rising `spi_sclk` while chip select is low and are compared only after the sequence has ended. The low phases of the serial clock and the chip-select gaps are counted in system clocks on every rising clock edge and checked against their limits once the sequence has ended.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int FRAME_W = 24;
    localparam int CFG_W   = 4;
    localparam int WORD_W  = 16;
    localparam int STEP_W  = 2;

    localparam logic [7:0] IDX_LEAD   = 8'h74;
    localparam logic [7:0] DAT_LEAD   = 8'h76;
    localparam logic [7:0] REG_POWER  = 8'h11;
    localparam logic [7:0] REG_OUTCTL = 8'h01;

    localparam logic [WORD_W-1:0] PANEL_ON    = 16'h0000;
    localparam logic [WORD_W-1:0] PANEL_OFF   = 16'h0001;
    localparam logic [WORD_W-1:0] MODE_BASE   = 16'h2AEF;
    localparam logic [WORD_W-1:0] ORIENT_MASK = 16'h3300;

    typedef enum logic [1:0] {
        OP_PWRUP  = 2'd0,
        OP_SHUT   = 2'd1,
        OP_RESUME = 2'd2
    } op_e;

    // Merge configuration bits into the fixed mode word.
    function automatic logic [WORD_W-1:0] mode_word_f(input logic [CFG_W-1:0] cfg);
        logic [WORD_W-1:0] w;
        w     = MODE_BASE & ~ORIENT_MASK;
        w[8]  = cfg[0];
        w[9]  = cfg[1];
        w[12] = cfg[2];
        w[13] = cfg[3];
        return w;
    endfunction

    // Index of the final frame of each sequence (two frames per write).
    function automatic logic [STEP_W-1:0] last_step_f(input op_e op);
        logic [STEP_W-1:0] s;
        unique case (op)
            OP_SHUT: s = 2'd1;
            default: s = 2'd3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pcs_frame_src.sv
module pcs_frame_src
    import pcs_pkg::*;
(
    input  op_e                      op,
    input  logic [STEP_W-1:0]        step,
    input  logic [WORD_W-1:0]        new_mode,
    input  logic [WORD_W-1:0]        kept_mode,
    output logic [FRAME_W-1:0]       frame,
    output logic [STEP_W-1:0]        last_step
);

    logic [7:0]        reg_sel;
    logic [WORD_W-1:0] value;
    logic              second_write;
    logic              data_phase;

    assign second_write = step[1];
    assign data_phase   = step[0];

    always_comb begin
        reg_sel = REG_POWER;
        value   = PANEL_ON;
        unique case (op)
            OP_PWRUP: begin
                if (second_write) begin
                    reg_sel = REG_OUTCTL;
                    value   = new_mode;
                end else begin
                    reg_sel = REG_POWER;
                    value   = PANEL_ON;
                end
            end
            OP_SHUT: begin
                reg_sel = REG_POWER;
                value   = PANEL_OFF;
            end
            default: begin
                if (second_write) begin
                    reg_sel = REG_POWER;
                    value   = PANEL_ON;
                end else begin
                    reg_sel = REG_OUTCTL;
                    value   = kept_mode;
                end
            end
        endcase
    end

    assign frame     = data_phase ? {DAT_LEAD, value} : {IDX_LEAD, 8'h00, reg_sel};
    assign last_step = last_step_f(op);

endmodule

// File: rtl/pcs_spi_tx.sv
module pcs_spi_tx
    import pcs_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               link_err,
    output logic               fin,
    output logic               fault,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
    localparam int BW = $clog2(FRAME_W);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(2 * HALF_DIV - 1);

    typedef enum logic [2:0] {
        P_IDLE, P_LEAD, P_LOW, P_HIGH, P_TRAIL, P_GAP
    } ph_e;

    typedef struct packed {
        ph_e                ph;
        logic [CW-1:0]      cnt;
        logic [BW-1:0]      bits;
        logic [FRAME_W-1:0] sh;
        logic               sclk;
        logic               csn;
        logic               fault;
        logic               fin;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        unique case (q.ph)
            P_IDLE: begin
                if (start) begin
                    d.ph    = P_LEAD;
                    d.cnt   = HALF_LAST;
                    d.csn   = 1'b0;
                    d.sh    = frame;
                    d.bits  = BW'(FRAME_W - 1);
                    d.fault = 1'b0;
                end
            end
            P_LEAD: begin
                if (q.cnt == '0) begin
                    d.ph   = P_LOW;
                    d.sclk = 1'b0;
                    d.cnt  = HALF_LAST;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            P_LOW: begin
                if (q.cnt == '0) begin
                    d.ph   = P_HIGH;
                    d.sclk = 1'b1;
                    d.cnt  = HALF_LAST;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            P_HIGH: begin
                if (q.cnt == '0) begin
                    if (q.bits == '0) begin
                        d.ph  = P_TRAIL;
                        d.cnt = HALF_LAST;
                    end else begin
                        d.bits = q.bits - 1'b1;
                        d.sh   = {q.sh[FRAME_W-2:0], 1'b0};
                        d.ph   = P_LOW;
                        d.sclk = 1'b0;
                        d.cnt  = HALF_LAST;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            P_TRAIL: begin
                if (q.cnt == '0) begin
                    d.csn = 1'b1;
                    d.ph  = P_GAP;
                    d.cnt = GAP_LAST;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            P_GAP: begin
                if (q.cnt == '0) begin
                    d.ph  = P_IDLE;
                    d.fin = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.ph = P_IDLE;
        endcase
        if (q.ph != P_IDLE && link_err) begin
            d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph    <= P_IDLE;
            q.cnt   <= '0;
            q.bits  <= '0;
            q.sh    <= '0;
            q.sclk  <= 1'b1;
            q.csn   <= 1'b1;
            q.fault <= 1'b0;
            q.fin   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign fin   = q.fin;
    assign fault = q.fault;
    assign sclk  = q.sclk;
    assign cs_n  = q.csn;
    assign mosi  = q.sh[FRAME_W-1];

endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_power_up,
    input  logic              cmd_shutdown,
    input  logic              cmd_resume,
    input  logic [CFG_W-1:0]  mode_cfg,
    input  logic              fin,
    input  logic              fault,
    input  logic [STEP_W-1:0] last_step,
    output logic              start,
    output op_e               op,
    output logic [STEP_W-1:0] step,
    output logic [WORD_W-1:0] new_mode,
    output logic [WORD_W-1:0] kept_mode,
    output logic              busy,
    output logic              done,
    output logic              error
);

    typedef enum logic [1:0] { S_IDLE, S_LAUNCH, S_WAIT } st_e;

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [STEP_W-1:0] step;
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] mode;
        logic              err;
        logic              done;
    } seq_t;

    seq_t q, d;
    logic any_cmd;
    logic err_now;

    assign any_cmd = cmd_power_up | cmd_shutdown | cmd_resume;
    assign err_now = q.err | fault;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        start  = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (any_cmd) begin
                    if (cmd_power_up)    d.op = OP_PWRUP;
                    else if (cmd_resume) d.op = OP_RESUME;
                    else                 d.op = OP_SHUT;
                    d.step = '0;
                    d.err  = 1'b0;
                    d.pend = mode_word_f(mode_cfg);
                    d.st   = S_LAUNCH;
                end
            end
            S_LAUNCH: begin
                start = 1'b1;
                d.st  = S_WAIT;
            end
            S_WAIT: begin
                if (fin) begin
                    d.err = err_now;
                    if (q.step == last_step) begin
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                        if (q.op == OP_PWRUP && !err_now) begin
                            d.mode = q.pend;
                        end
                    end else begin
                        d.step = q.step + 1'b1;
                        d.st   = S_LAUNCH;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.op   <= OP_PWRUP;
            q.step <= '0;
            q.pend <= mode_word_f('0);
            q.mode <= mode_word_f('0);
            q.err  <= 1'b0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign op        = q.op;
    assign step      = q.step;
    assign new_mode  = q.pend;
    assign kept_mode = q.mode;
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign error     = q.err;

endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
    import pcs_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_power_up,
    input  logic        cmd_shutdown,
    input  logic        cmd_resume,
    input  logic [3:0]  mode_cfg,
    input  logic        link_err,
    output logic        busy,
    output logic        done,
    output logic        error,
    output logic [15:0] mode_word,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi
);

    op_e               op;
    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] last_step;
    logic [WORD_W-1:0] new_mode;
    logic [FRAME_W-1:0] frame;
    logic              start;
    logic              fin;
    logic              fault;

    pcs_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_power_up (cmd_power_up),
        .cmd_shutdown (cmd_shutdown),
        .cmd_resume   (cmd_resume),
        .mode_cfg     (mode_cfg),
        .fin          (fin),
        .fault        (fault),
        .last_step    (last_step),
        .start        (start),
        .op           (op),
        .step         (step),
        .new_mode     (new_mode),
        .kept_mode    (mode_word),
        .busy         (busy),
        .done         (done),
        .error        (error)
    );

    pcs_frame_src u_src (
        .op        (op),
        .step      (step),
        .new_mode  (new_mode),
        .kept_mode (mode_word),
        .frame     (frame),
        .last_step (last_step)
    );

    pcs_spi_tx #(.HALF_DIV(HALF_DIV)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame    (frame),
        .link_err (link_err),
        .fin      (fin),
        .fault    (fault),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi)
    );

endmodule

// File: rtl/pcs_chk.sv
module pcs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_power_up,
    input logic        cmd_shutdown,
    input logic        cmd_resume,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic [15:0] mode_word,
    input logic        spi_sclk,
    input logic        spi_cs_n,
    input logic        spi_mosi
);

    logic any_cmd;
    assign any_cmd = cmd_power_up | cmd_shutdown | cmd_resume;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
    AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && any_cmd) |=> busy); // R10
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sclk); // R2
    AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !$past(spi_cs_n) && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R2
    AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n); // R1
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(mode_word)); // R9
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !any_cmd) |=> $stable(error)); // R8

endmodule

bind panel_cfg_seq pcs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_power_up (cmd_power_up),
    .cmd_shutdown (cmd_shutdown),
    .cmd_resume   (cmd_resume),
    .busy         (busy),
    .done         (done),
    .error        (error),
    .mode_word    (mode_word),
    .spi_sclk     (spi_sclk),
    .spi_cs_n     (spi_cs_n),
    .spi_mosi     (spi_mosi)
);

// File: tb/tb_panel_cfg_seq.sv
module tb_panel_cfg_seq;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_power_up = 1'b0;
    logic        cmd_shutdown = 1'b0;
    logic        cmd_resume = 1'b0;
    logic [3:0]  mode_cfg = 4'h0;
    logic        link_err = 1'b0;
    logic        busy, done, error;
    logic [15:0] mode_word;
    logic        spi_sclk, spi_cs_n, spi_mosi;

    always #5 clk = ~clk;

    panel_cfg_seq #(.HALF_DIV(HALF)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_power_up (cmd_power_up),
        .cmd_shutdown (cmd_shutdown),
        .cmd_resume   (cmd_resume),
        .mode_cfg     (mode_cfg),
        .link_err     (link_err),
        .busy         (busy),
        .done         (done),
        .error        (error),
        .mode_word    (mode_word),
        .spi_sclk     (spi_sclk),
        .spi_cs_n     (spi_cs_n),
        .spi_mosi     (spi_mosi)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Vector: {op[1:0] (0 power-up, 1 shutdown, 2 resume), cfg[3:0], inject[1:0]}
    // inject: 0 none, 1 fault in first frame, 2 fault in last frame
    localparam logic [7:0] VEC [8] = '{
        8'b00_0101_00, 8'b10_0000_00, 8'b01_0000_00, 8'b00_1010_01,
        8'b10_0000_10, 8'b00_1111_00, 8'b01_0000_01, 8'b10_0000_00
    };

    // Frame capture from the serial pins
    logic [23:0] cap [16];
    int          cap_bits [16];
    int          nfr = 0;
    logic [23:0] cur = '0;
    int          bitc = 0;

    always @(posedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            cur  = {cur[22:0], spi_mosi};
            bitc = bitc + 1;
        end
    end

    always @(posedge spi_cs_n) begin
        if (bitc > 0) begin
            if (nfr < 16) begin
                cap[nfr]      = cur;
                cap_bits[nfr] = bitc;
            end
            nfr  = nfr + 1;
            bitc = 0;
        end
    end

    // Timing monitors in system clocks
    int hi_run = 0, min_gap = 9999, lo_run = 0, lo_min = 9999, lo_max = 0;
    bit had_frame = 0;

    always @(posedge clk) begin
        if (spi_cs_n === 1'b1) begin
            hi_run = hi_run + 1;
        end else if (spi_cs_n === 1'b0) begin
            if (had_frame && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run    = 0;
            had_frame = 1;
        end
        if (spi_sclk === 1'b0) begin
            lo_run = lo_run + 1;
        end else if (lo_run > 0) begin
            if (lo_run < lo_min) lo_min = lo_run;
            if (lo_run > lo_max) lo_max = lo_run;
            lo_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_mode(input logic [3:0] c);
        logic [15:0] m;
        m = 16'h08EF;
        if (c[0]) m = m | 16'h0100;
        if (c[1]) m = m | 16'h0200;
        if (c[2]) m = m | 16'h1000;
        if (c[3]) m = m | 16'h2000;
        return m;
    endfunction

    function automatic logic [23:0] exp_frame(input int op, input int k,
                                              input logic [15:0] nm, input logic [15:0] om);
        logic [7:0]  r;
        logic [15:0] v;
        if (op == 0) begin
            r = (k < 2) ? 8'h11 : 8'h01;
            v = (k < 2) ? 16'h0000 : nm;
        end else if (op == 1) begin
            r = 8'h11;
            v = 16'h0001;
        end else begin
            r = (k < 2) ? 8'h01 : 8'h11;
            v = (k < 2) ? om : 16'h0000;
        end
        return (k % 2 == 0) ? {8'h74, 8'h00, r} : {8'h76, v};
    endfunction

    logic [15:0] model_mode = 16'h08EF;

    // variant: 0 plain, 1 shutdown pulse while busy, 2 all commands at once
    task automatic run(input int op, input logic [3:0] cfg, input int inj, input int variant);
        int          expn;
        bit          exp_err;
        logic [15:0] nm;
        string       tag;
        expn    = (op == 1) ? 2 : 4;
        exp_err = (inj != 0);
        nm      = exp_mode(cfg);
        tag     = (op == 0) ? "R4" : (op == 1) ? "R5" : "R6";
        nfr = 0; bitc = 0; min_gap = 9999; lo_min = 9999; lo_max = 0; had_frame = 0;
        @(negedge clk);
        mode_cfg = cfg;
        if (variant == 2) begin
            cmd_power_up = 1; cmd_shutdown = 1; cmd_resume = 1;
        end else begin
            cmd_power_up = (op == 0); cmd_shutdown = (op == 1); cmd_resume = (op == 2);
        end
        @(negedge clk);
        cmd_power_up = 0; cmd_shutdown = 0; cmd_resume = 0;
        mode_cfg = ~cfg;
        chk(busy === 1'b1, "R11", "busy one cycle after command", busy, 1);
        if (variant == 1) begin
            repeat (20) @(negedge clk);
            cmd_shutdown = 1;
            @(negedge clk);
            cmd_shutdown = 0;
        end
        if (inj != 0) begin
            wait (nfr == ((inj == 1) ? 0 : expn - 1));
            @(negedge spi_cs_n);
            @(negedge clk);
            link_err = 1;
            @(negedge clk);
            link_err = 0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(busy === 1'b0, "R11", "busy low with done", busy, 0);
        chk(error === exp_err, "R8", "error flag at done", error, exp_err);
        chk(nfr == expn, tag, "frame count", nfr, expn);
        for (int k = 0; k < expn && k < 16; k++) begin
            chk(cap_bits[k] == 24, "R1", "bits per frame", cap_bits[k], 24);
            chk(cap[k] === exp_frame(op, k, nm, model_mode), tag, "frame content",
                cap[k], exp_frame(op, k, nm, model_mode));
        end
        if (op == 0 && !exp_err) model_mode = nm;
        chk(mode_word === model_mode, (op == 0 && !exp_err) ? "R7" : "R9",
            "stored mode word", mode_word, model_mode);
        chk(min_gap >= 2 * HALF, "R3", "chip select gap", min_gap, 2 * HALF);
        chk(lo_min == HALF && lo_max == HALF, "R2", "sclk low width", lo_min, HALF);
        @(negedge clk);
        chk(done === 1'b0, "R11", "done one cycle", done, 0);
        if (variant == 1) begin
            repeat (300) @(negedge clk);
            chk(nfr == expn && busy === 1'b0, "R10", "command while busy ignored", nfr, expn);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b1, "R12", "link idle in reset",
            {spi_cs_n, spi_sclk}, 2'b11);
        rst_n = 1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R12", "flags after reset",
            {busy, done, error}, 0);
        chk(mode_word === 16'h08EF, "R12", "mode word after reset", mode_word, 16'h08EF);

        // Resume before any power-up uses the reset mode word (R6)
        run(2, 4'h0, 0, 0);

        for (int i = 0; i < 8; i++) begin
            run(int'(VEC[i][7:6]), VEC[i][5:2], int'(VEC[i][1:0]), 0);
        end

        // link_err while idle is ignored (R8)
        @(negedge clk);
        link_err = 1;
        repeat (5) @(negedge clk);
        link_err = 0;
        run(1, 4'h0, 0, 0);

        // Command while busy ignored (R10)
        run(0, 4'h3, 0, 1);
        // Simultaneous commands: power-up wins (R10)
        run(0, 4'hC, 0, 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule